// File: doc/BRIEF.md
# SIMD Processing Node Datapath

One node of a single-instruction, multiple-data array. All nodes of the array see the same instruction word on every clock. Each node keeps a local enable flag. A compare instruction sets or clears that flag. While the flag is low, the node skips every write to its registers, its accumulator and its memory port. A shared 8-bit input bus carries broadcast operands into the node. An 8-bit output bus carries results out. Outside the node the output bus is tied back to the input bus, so one node can broadcast to all the others. A broadcast node index picks the single node that drives the output bus.

The datapath holds a register file of 32 words of 16 bits, a 32-bit accumulator, a 9-bit by 16-bit signed multiplier, an arithmetic shifter and a logic unit.

The multiply-accumulate instruction takes a broadcast byte, multiplies it by a register and adds the product to the accumulator in one clock. This is one inner-product step per clock. A full signed 16x16 multiply-accumulate reuses the same multiplier over two clocks: first the unsigned low byte of the second operand, then its signed high byte shifted left by eight. Local memory is outside the node and is reached through a plain port: the address and write data are combinational, and the read data returns in the same cycle.

Top module: `simd_pe_node`

## Requirements
- R1: After reset the accumulator and all registers are zero, the enable flag is high and out_valid_o is low.
- R2: SHIN (op 1) writes {rd[7:0], bus_in_i} into register rd, so two SHIN instructions load a 16-bit word with the high byte first.
- R3: MACB (op 5) adds the product of the unsigned bus byte (0..255) and signed register ra to the accumulator, and the new value is visible from the next cycle.
- R4: MACW (op 6), when the flag is high, adds the signed 16x16 product of registers ra and rb to the accumulator over two clocks. Whatever instruction arrives in the second clock is ignored.
- R5: CMPGE (op 12) always executes, even when the flag is low. It sets the flag to (signed ra >= signed rb).
- R6: While the flag is low, register writes, accumulator writes (including MACW) and memory writes are suppressed, and MACW takes no second cycle.
- R7: OUT (op 13) drives out_bus_o and raises out_valid_o one cycle later, only if sel_id_i equals node_id_i. With rb[2]=0 the byte is accumulator byte rb[1:0]. With rb[2]=1 it is byte rb[0] of register ra (0 = low byte).
- R8: SHRA (op 7) shifts the accumulator arithmetically right by the 5-bit literal in the rb field.
- R9: AND (op 8), OR (op 9) and XOR (op 10) write ra op rb into rd. MOV (op 2) copies ra into rd.
- R10: ADD (op 3) adds sign-extended register ra to the accumulator. CLRA (op 4) clears it. STA (op 11) writes accumulator bits [15:0] into rd.
- R11: ST (op 15) raises mem_we_o with address ra[9:0] and data rd. LD (op 14) writes mem_rdata_i into rd with the address taken from ra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Broadcast opcode |
| rd_i | input | 5 | Destination register field |
| ra_i | input | 5 | First source register field |
| rb_i | input | 5 | Second source register field or literal |
| bus_in_i | input | 8 | Shared input bus |
| node_id_i | input | 6 | This node's index (strap) |
| sel_id_i | input | 6 | Broadcast index of the node that drives the output bus |
| out_bus_o | output | 8 | Output bus byte |
| out_valid_o | output | 1 | This node drives the output bus |
| mem_addr_o | output | 10 | Local memory address |
| mem_wdata_o | output | 16 | Local memory write data |
| mem_we_o | output | 1 | Local memory write enable |
| mem_rdata_i | input | 16 | Local memory read data, same cycle |

## Verification
The hardest situation to reach from the ports is an instruction that lands in the second clock of a MACW. A second case is a MACW issued while the flag is low. In that case the very next instruction must not be swallowed. The stimulus issues a MACW and follows it at once with a CLRA. It then reads the accumulator out byte by byte over the output bus and checks that the CLRA had no effect. A compare first forces the flag low, and the same pair is repeated: this time the CLRA is skipped because the flag is low, and a compare placed right after the disabled MACW must take effect.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_SHIN  = 4'd1,
    OP_MOV   = 4'd2,
    OP_ADD   = 4'd3,
    OP_CLRA  = 4'd4,
    OP_MACB  = 4'd5,
    OP_MACW  = 4'd6,
    OP_SHRA  = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_XOR   = 4'd10,
    OP_STA   = 4'd11,
    OP_CMPGE = 4'd12,
    OP_OUT   = 4'd13,
    OP_LD    = 4'd14,
    OP_ST    = 4'd15
  } pe_op_e;

  typedef enum logic [1:0] {
    LU_PASS = 2'd0,
    LU_AND  = 2'd1,
    LU_OR   = 2'd2,
    LU_XOR  = 2'd3
  } lu_fn_e;
endpackage

// File: rtl/pe_regfile.sv
module pe_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] raddr_a_i,
  input  logic [RW-1:0] raddr_b_i,
  input  logic [RW-1:0] raddr_c_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o,
  output logic [DW-1:0] rdata_c_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && waddr_i == RW'(g))           regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign rdata_c_o = regs_q[raddr_c_i];
endmodule

// File: rtl/pe_mul.sv
// Signed narrow-by-wide multiplier, one product per clock.
module pe_mul #(
  parameter int NW = 9,
  parameter int WW = 16,
  localparam int PW = NW + WW
) (
  input  logic [NW-1:0] a_i,
  input  logic [WW-1:0] b_i,
  output logic [PW-1:0] p_o
);
  logic signed [PW-1:0] prod;
  always_comb prod = PW'($signed(a_i)) * PW'($signed(b_i));
  assign p_o = prod;
endmodule

// File: rtl/pe_logic.sv
module pe_logic
  import simd_pe_pkg::*;
#(
  parameter int DW = 16
) (
  input  lu_fn_e        fn_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      LU_AND:  y_o = a_i & b_i;
      LU_OR:   y_o = a_i | b_i;
      LU_XOR:  y_o = a_i ^ b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/simd_pe_node.sv
module simd_pe_node
  import simd_pe_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 16,
  parameter int AW   = 32,
  parameter int BW   = 8,
  parameter int IDW  = 6,
  parameter int MAW  = 10,
  localparam int RW  = $clog2(NREG),
  localparam int NW  = BW + 1,
  localparam int PW  = NW + DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [3:0]     op_i,
  input  logic [RW-1:0]  rd_i,
  input  logic [RW-1:0]  ra_i,
  input  logic [RW-1:0]  rb_i,
  input  logic [BW-1:0]  bus_in_i,
  input  logic [IDW-1:0] node_id_i,
  input  logic [IDW-1:0] sel_id_i,
  output logic [BW-1:0]  out_bus_o,
  output logic           out_valid_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_we_o,
  input  logic [DW-1:0]  mem_rdata_i
);
  pe_op_e op_eff;
  logic          flag_q, busy_q;
  logic [DW-1:0] hold_a_q, hold_b_q;
  logic [AW-1:0] acc_q, acc_d;
  logic          acc_we, rf_we;
  logic [DW-1:0] ra_v, rb_v, rd_v, rf_wdata, lu_y;
  logic [NW-1:0] mul_a;
  logic [DW-1:0] mul_b;
  logic [PW-1:0] mul_p;
  logic [AW-1:0] prod_ext;
  lu_fn_e        lu_fn;
  logic [BW-1:0] out_d;
  logic          out_valid_q;
  logic [BW-1:0] out_q;

  // second clock of a wide multiply swallows the incoming instruction
  assign op_eff = busy_q ? OP_NOP : pe_op_e'(op_i);

  pe_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(rd_i), .wdata_i(rf_wdata),
    .raddr_a_i(ra_i), .raddr_b_i(rb_i), .raddr_c_i(rd_i),
    .rdata_a_o(ra_v), .rdata_b_o(rb_v), .rdata_c_o(rd_v)
  );

  always_comb begin
    if (busy_q)               mul_a = {hold_b_q[DW-1], hold_b_q[DW-1 -: BW]};
    else if (op_eff == OP_MACW) mul_a = {1'b0, rb_v[BW-1:0]};
    else                      mul_a = {1'b0, bus_in_i};
    mul_b = busy_q ? hold_a_q : ra_v;
  end

  pe_mul #(.NW(NW), .WW(DW)) u_mul (.a_i(mul_a), .b_i(mul_b), .p_o(mul_p));

  always_comb begin
    prod_ext = AW'($signed(mul_p));
    if (busy_q) prod_ext = prod_ext << BW;
  end

  always_comb begin
    unique case (op_eff)
      OP_AND:  lu_fn = LU_AND;
      OP_OR:   lu_fn = LU_OR;
      OP_XOR:  lu_fn = LU_XOR;
      default: lu_fn = LU_PASS;
    endcase
  end

  pe_logic #(.DW(DW)) u_lu (.fn_i(lu_fn), .a_i(ra_v), .b_i(rb_v), .y_o(lu_y));

  always_comb begin
    acc_d  = acc_q;
    acc_we = 1'b0;
    if (busy_q) begin
      acc_d  = acc_q + prod_ext;
      acc_we = 1'b1;
    end else begin
      unique case (op_eff)
        OP_ADD:  begin acc_d = acc_q + AW'($signed(ra_v)); acc_we = flag_q; end
        OP_CLRA: begin acc_d = '0;                         acc_we = flag_q; end
        OP_MACB,
        OP_MACW: begin acc_d = acc_q + prod_ext;           acc_we = flag_q; end
        OP_SHRA: begin acc_d = $signed(acc_q) >>> rb_i;    acc_we = flag_q; end
        default: ;
      endcase
    end
  end

  always_comb begin
    rf_wdata = lu_y;
    rf_we    = 1'b0;
    unique case (op_eff)
      OP_SHIN: begin rf_wdata = {rd_v[DW-BW-1:0], bus_in_i}; rf_we = flag_q; end
      OP_LD:   begin rf_wdata = mem_rdata_i;                 rf_we = flag_q; end
      OP_STA:  begin rf_wdata = acc_q[DW-1:0];               rf_we = flag_q; end
      OP_MOV, OP_AND, OP_OR, OP_XOR: rf_we = flag_q;
      default: ;
    endcase
  end

  always_comb begin
    if (rb_i[2]) out_d = rb_i[0] ? ra_v[DW-1 -: BW] : ra_v[BW-1:0];
    else         out_d = acc_q[rb_i[1:0]*BW +: BW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      flag_q      <= 1'b1;
      busy_q      <= 1'b0;
      hold_a_q    <= '0;
      hold_b_q    <= '0;
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else begin
      if (acc_we) acc_q <= acc_d;
      if (op_eff == OP_CMPGE) flag_q <= $signed(ra_v) >= $signed(rb_v);
      busy_q <= (op_eff == OP_MACW) && flag_q;
      if (op_eff == OP_MACW) begin
        hold_a_q <= ra_v;
        hold_b_q <= rb_v;
      end
      out_valid_q <= (op_eff == OP_OUT) && (sel_id_i == node_id_i);
      if ((op_eff == OP_OUT) && (sel_id_i == node_id_i)) out_q <= out_d;
    end
  end

  assign out_bus_o   = out_valid_q ? out_q : '0;
  assign out_valid_o = out_valid_q;
  assign mem_addr_o  = ra_v[MAW-1:0];
  assign mem_wdata_o = rd_v;
  assign mem_we_o    = flag_q && (op_eff == OP_ST);
endmodule

// File: rtl/simd_pe_node_chk.sv
module simd_pe_node_chk
  import simd_pe_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [3:0]     op_i,
  input logic [IDW-1:0] node_id_i,
  input logic [IDW-1:0] sel_id_i,
  input logic           out_valid_o,
  input logic           mem_we_o,
  input logic           flag_q,
  input logic           busy_q,
  input logic [AW-1:0]  acc_q
);
  // R6: a low flag freezes the accumulator
  a_r6_acc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !busy_q) |=> $stable(acc_q));

  // R6: no memory write while disabled
  a_r6_no_mem_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> flag_q);

  // R4: wide multiply occupies exactly one extra clock
  a_r4_busy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);

  // R4: second clock only follows an enabled MACW
  a_r4_busy_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> $past(op_i == OP_MACW && flag_q && !busy_q));

  // R4: instruction in the second clock cannot move the flag
  a_r4_flag_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(flag_q));

  // R7: only the indexed node drives the output bus
  a_r7_out_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(op_i == OP_OUT && sel_id_i == node_id_i && !busy_q));
endmodule

bind simd_pe_node simd_pe_node_chk #(.AW(AW), .IDW(IDW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i),
  .node_id_i(node_id_i), .sel_id_i(sel_id_i),
  .out_valid_o(out_valid_o), .mem_we_o(mem_we_o),
  .flag_q(flag_q), .busy_q(busy_q), .acc_q(acc_q)
);

// File: tb/sim_simd_pe_node.sv
`timescale 1ns/1ps
module sim_simd_pe_node;
  import simd_pe_pkg::*;

  localparam logic [5:0] MY_ID = 6'd3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [4:0]  rd_i = '0, ra_i = '0, rb_i = '0;
  logic [7:0]  bus_in_i = '0;
  logic [5:0]  sel_id_i = '0;
  logic [7:0]  out_bus_o;
  logic        out_valid_o;
  logic [9:0]  mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_we_o;
  logic [15:0] mem_rdata_i;
  logic [15:0] mem [64];

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  simd_pe_node u0 (
    .clk_i, .rst_ni, .op_i, .rd_i, .ra_i, .rb_i, .bus_in_i,
    .node_id_i(MY_ID), .sel_id_i, .out_bus_o, .out_valid_o,
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_rdata_i
  );

  assign mem_rdata_i = mem[mem_addr_o[5:0]];
  always_ff @(posedge clk_i) if (mem_we_o) mem[mem_addr_o[5:0]] <= mem_wdata_o;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input pe_op_e op, input logic [4:0] rd, input logic [4:0] ra,
                       input logic [4:0] rb, input logic [7:0] bus, input logic [5:0] sel);
    @(negedge clk_i);
    op_i = op; rd_i = rd; ra_i = ra; rb_i = rb; bus_in_i = bus; sel_id_i = sel;
    @(posedge clk_i);
    #1;
  endtask

  task automatic out_byte(input logic [2:0] sel, input logic [4:0] ra, output logic [7:0] b);
    issue(OP_OUT, 5'd0, ra, {2'b0, sel}, 8'h00, MY_ID);
    b = out_bus_o;
    chk("R7 out_valid", {31'b0, out_valid_o}, 32'd1);
  endtask

  task automatic read_acc(output logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      out_byte(3'(i), 5'd0, b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic read_reg(input logic [4:0] r, output logic [15:0] v);
    logic [7:0] lo, hi;
    out_byte(3'b100, r, lo);
    out_byte(3'b101, r, hi);
    v = {hi, lo};
  endtask

  task automatic load16(input logic [4:0] r, input logic [15:0] v);
    issue(OP_SHIN, r, 5'd0, 5'd0, v[15:8], 6'd0);
    issue(OP_SHIN, r, 5'd0, 5'd0, v[7:0], 6'd0);
  endtask

  task automatic t_reset;
    logic [31:0] a; logic [15:0] r;
    chk("R1 out_valid low", {31'b0, out_valid_o}, 32'd0);
    read_acc(a);
    chk("R1 acc zero", a, 32'd0);
    read_reg(5'd9, r);
    chk("R1 reg zero", {16'b0, r}, 32'd0);
    issue(OP_CLRA, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0);
    issue(OP_ADD, 5'd0, 5'd9, 5'd0, 8'h00, 6'd0);
    issue(OP_ADD, 5'd0, 5'd9, 5'd0, 8'h00, 6'd0);
    read_acc(a);
    chk("R1 flag high at reset", a, 32'd0);
  endtask

  task automatic t_shin;
    logic [15:0] r;
    load16(5'd1, 16'h1234);
    read_reg(5'd1, r);
    chk("R2 shin load", {16'b0, r}, 32'h1234);
  endtask

  task automatic t_macb;
    logic [31:0] a;
    load16(5'd2, 16'hFFFD);
    load16(5'd3, 16'd1000);
    issue(OP_CLRA, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0);
    issue(OP_MACB, 5'd0, 5'd2, 5'd0, 8'd200, 6'd0);
    read_acc(a);
    chk("R3 macb single", a, 32'hFFFF_FDA8);
    issue(OP_MACB, 5'd0, 5'd3, 5'd0, 8'd7, 6'd0);
    issue(OP_MACB, 5'd0, 5'd3, 5'd0, 8'd255, 6'd0);
    read_acc(a);
    chk("R3 macb chain", a, 32'(-600 + 7000 + 255000));
  endtask

  task automatic t_macw;
    logic [31:0] a;
    load16(5'd4, 16'(-1234));
    load16(5'd5, 16'h8001);
    issue(OP_CLRA, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0);
    issue(OP_MACW, 5'd0, 5'd4, 5'd5, 8'h00, 6'd0);
    issue(OP_CLRA, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0); // lands in second clock
    read_acc(a);
    chk("R4 macw signed", a, 32'(1234 * 32767));
    load16(5'd6, 16'h00FF);
    load16(5'd7, 16'd300);
    issue(OP_CLRA, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0);
    issue(OP_MACW, 5'd0, 5'd7, 5'd6, 8'h00, 6'd0);
    issue(OP_NOP, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0);
    read_acc(a);
    chk("R4 macw low slice", a, 32'd76500);
  endtask

  task automatic t_flag;
    logic [31:0] a; logic [15:0] r;
    issue(OP_CMPGE, 5'd0, 5'd2, 5'd3, 8'h00, 6'd0); // -3 >= 1000 false
    issue(OP_CLRA, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0);
    issue(OP_MOV, 5'd1, 5'd3, 5'd0, 8'h00, 6'd0);
    issue(OP_SHIN, 5'd1, 5'd0, 5'd0, 8'hAA, 6'd0);
    issue(OP_ST, 5'd1, 5'd3, 5'd0, 8'h00, 6'd0);
    read_acc(a);
    chk("R6 acc kept", a, 32'd76500);
    read_reg(5'd1, r);
    chk("R6 reg kept", {16'b0, r}, 32'h1234);
    chk("R6 mem untouched", {16'b0, mem[1000 % 64]}, 32'h0);
    issue(OP_MACW, 5'd0, 5'd4, 5'd5, 8'h00, 6'd0);
    issue(OP_CMPGE, 5'd0, 5'd3, 5'd3, 8'h00, 6'd0); // must not be swallowed
    issue(OP_CLRA, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0);
    read_acc(a);
    chk("R5 cmpge equal reenables", a, 32'd0);
    issue(OP_CMPGE, 5'd0, 5'd3, 5'd2, 8'h00, 6'd0); // 1000 >= -3 true
    issue(OP_ADD, 5'd0, 5'd3, 5'd0, 8'h00, 6'd0);
    read_acc(a);
    chk("R5 cmpge signed true", a, 32'd1000);
  endtask

  task automatic t_out;
    logic [7:0] b;
    issue(OP_OUT, 5'd0, 5'd1, 5'd4, 8'h00, MY_ID + 6'd1);
    chk("R7 other node no drive", {31'b0, out_valid_o}, 32'd0);
    out_byte(3'b101, 5'd1, b);
    chk("R7 reg high byte", {24'b0, b}, 32'h12);
    issue(OP_NOP, 5'd0, 5'd0, 5'd0, 8'h00, MY_ID);
    chk("R7 drive one cycle", {31'b0, out_valid_o}, 32'd0);
  endtask

  task automatic t_shift_add;
    logic [31:0] a; logic [15:0] r;
    load16(5'd8, 16'hFF00);
    issue(OP_CLRA, 5'd0, 5'd0, 5'd0, 8'h00, 6'd0);
    issue(OP_ADD, 5'd0, 5'd8, 5'd0, 8'h00, 6'd0);
    read_acc(a);
    chk("R10 add sign extend", a, 32'hFFFF_FF00);
    issue(OP_SHRA, 5'd0, 5'd0, 5'd4, 8'h00, 6'd0);
    read_acc(a);
    chk("R8 shra arithmetic", a, 32'hFFFF_FFF0);
    issue(OP_STA, 5'd10, 5'd0, 5'd0, 8'h00, 6'd0);
    read_reg(5'd10, r);
    chk("R10 sta low half", {16'b0, r}, 32'hFFF0);
  endtask

  task automatic t_logic;
    logic [15:0] r;
    load16(5'd11, 16'hF0F0);
    load16(5'd12, 16'h3C3C);
    issue(OP_AND, 5'd13, 5'd11, 5'd12, 8'h00, 6'd0);
    issue(OP_OR,  5'd14, 5'd11, 5'd12, 8'h00, 6'd0);
    issue(OP_XOR, 5'd15, 5'd11, 5'd12, 8'h00, 6'd0);
    issue(OP_MOV, 5'd16, 5'd12, 5'd0, 8'h00, 6'd0);
    read_reg(5'd13, r); chk("R9 and", {16'b0, r}, 32'h3030);
    read_reg(5'd14, r); chk("R9 or",  {16'b0, r}, 32'hFCFC);
    read_reg(5'd15, r); chk("R9 xor", {16'b0, r}, 32'hCCCC);
    read_reg(5'd16, r); chk("R9 mov", {16'b0, r}, 32'h3C3C);
  endtask

  task automatic t_mem;
    logic [15:0] r;
    load16(5'd17, 16'd5);
    issue(OP_ST, 5'd1, 5'd17, 5'd0, 8'h00, 6'd0);
    chk("R11 st stored", {16'b0, mem[5]}, 32'h1234);
    issue(OP_LD, 5'd18, 5'd17, 5'd0, 8'h00, 6'd0);
    read_reg(5'd18, r);
    chk("R11 ld readback", {16'b0, r}, 32'h1234);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_shin();
    t_macb();
    t_macw();
    t_flag();
    t_out();
    t_shift_add();
    t_logic();
    t_mem();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule